// File: doc/BRIEF.md
# Flag-Setting Integer Execution Unit

This block is the integer execute stage of a small core. Each accepted operation takes a destination value D, a source value S and an operation code. One cycle later it presents the new destination value, a write strobe and three flags. The flags are a carry flag (CF), a zero flag (ZF) and a sign flag (SF). The unit holds the three flags itself, so add-with-carry and the rotates through carry consume the carry left by earlier operations.

The operation set covers several groups:
- add, subtract, negate, increment and decrement;
- bitwise logic and a plain copy;
- logical and arithmetic shifts;
- rotates, both plain and through carry;
- single-bit test, clear and set at a bit index taken from S;
- forcing the carry flag to zero or one;
- compare and test, which change only the flags and leave D untouched.

The datapath width is a parameter (a power of two, default 32). Shift counts and bit indices use the low log2(WIDTH) bits of S.

Top module: `flag_alu`

## Requirements
- R1: While reset is low, and after its release until the first accepted operation, done_o, wr_o, res_o, cf_o, zf_o and sf_o are all 0.
- R2: The arithmetic operations are ADD (code 1), ADDC (code 2), SUB (code 3), NEG (code 5), INC (code 6) and DEC (code 7). They produce D+S, D+S+CF, D-S, 0-D, D+1 and D-1 modulo 2^WIDTH. ADD and ADDC set CF to the carry out. SUB sets CF to the borrow (D<S unsigned). NEG sets CF when D is nonzero. INC and DEC keep CF.
- R3: CMP (code 4) sets the flags from D-S, with CF as the borrow. TEST (code 12) sets the flags from D AND S and clears CF. For both, wr_o is 0 and res_o equals D.
- R4: AND, OR, XOR (codes 8, 9, 10) and NOT of D (code 11) write their result and clear CF. MOVE (code 0) writes S and leaves all three flags unchanged.
- R5: Left shift SLL (code 13) and logical right shift SRL (code 14) fill with zeros. Arithmetic right shift SRA (code 15) replicates the sign bit. CF takes the last bit shifted out. With a count of 0 the result is D and CF is kept.
- R6: ROTL (code 16) and ROTR (code 17) rotate D within WIDTH bits. On a nonzero count, CF takes the bit that landed in bit 0 (ROTL) or in the top bit (ROTR). ZF and SF are unchanged.
- R7: RCL (code 18) and RCR (code 19) rotate the WIDTH+1-bit ring {CF, D} left or right by the count. The ring's top bit becomes the new CF. ZF and SF are unchanged.
- R8: Shift and rotate counts and bit indices use only the low log2(WIDTH) bits of S. Higher bits of S have no effect on these operations.
- R9: BTST (code 20) copies bit idx of D into CF and does not write. BCLR (code 21) and BSET (code 22) also copy that bit into CF, then write D with the bit cleared or set. ZF and SF are unchanged.
- R10: CCLR (code 23) forces CF to 0 and CSET (code 24) forces CF to 1. Neither writes D or changes ZF and SF.
- R11: ZF is 1 exactly when the operation's value is zero, and SF is the top bit of that value. This holds for every operation of R2, R3 and R5 and for AND, OR, XOR and NOT.
- R12: An operation accepted on a clock edge (valid_i high) shows its result one cycle later, with done_o high. While valid_i is low, done_o and wr_o fall to 0 and res_o and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Accept an operation this cycle |
| op_i | input | 5 | Operation code (codes listed in the requirements) |
| d_i | input | WIDTH | Destination operand D |
| s_i | input | WIDTH | Source operand S, or count/index in its low bits |
| done_o | output | 1 | Result of the previous accepted operation is shown |
| wr_o | output | 1 | res_o is to be written back to D |
| res_o | output | WIDTH | New D value (D itself for flag-only operations) |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |

## Verification
The bench targets several corner cases, each with a distinct wrong outcome:
- **Count or index of zero:** a shifter that does not gate the carry would clobber CF with a pad bit.
- **Counts with high bits set in S:** an unmasked count would shift everything out.
- **Wrap points of add-with-carry and subtract:** a design with the borrow polarity inverted would flip CF on every compare.
- **Rotates through carry:** an off-by-one ring width would lose or duplicate the carry bit.
- **Bit operations and carry forcing:** a design that updated ZF and SF there would show flags that do not match the surrounding arithmetic results.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   localparam int unsigned OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_MOVE = 5'd0,
      OP_ADD  = 5'd1,
      OP_ADDC = 5'd2,
      OP_SUB  = 5'd3,
      OP_CMP  = 5'd4,
      OP_NEG  = 5'd5,
      OP_INC  = 5'd6,
      OP_DEC  = 5'd7,
      OP_AND  = 5'd8,
      OP_OR   = 5'd9,
      OP_XOR  = 5'd10,
      OP_NOT  = 5'd11,
      OP_TEST = 5'd12,
      OP_SLL  = 5'd13,
      OP_SRL  = 5'd14,
      OP_SRA  = 5'd15,
      OP_ROTL = 5'd16,
      OP_ROTR = 5'd17,
      OP_RCL  = 5'd18,
      OP_RCR  = 5'd19,
      OP_BTST = 5'd20,
      OP_BCLR = 5'd21,
      OP_BSET = 5'd22,
      OP_CCLR = 5'd23,
      OP_CSET = 5'd24
   } alu_op_e;

   typedef enum logic [1:0] {
      UNIT_ARITH = 2'd0,
      UNIT_SHIFT = 2'd1,
      UNIT_LOGIC = 2'd2
   } alu_unit_e;

   typedef struct packed {
      alu_unit_e unit;
      logic      wr;
      logic      upd_zs;
   } alu_ctl_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
   import flag_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] d,
   input  logic [WIDTH-1:0] s,
   input  logic             cin,
   output logic [WIDTH-1:0] val,
   output logic             co,
   output logic             co_en
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] a, b;
   logic             c_in;
   logic             sub_sel;
   logic [WIDTH:0]   ext;

   always_comb begin
      a       = d;
      b       = s;
      c_in    = 1'b0;
      sub_sel = 1'b0;
      co_en   = 1'b1;
      unique case (op)
         OP_ADD:         ;
         OP_ADDC:        c_in = cin;
         OP_SUB, OP_CMP: sub_sel = 1'b1;
         OP_NEG: begin
            a       = '0;
            b       = d;
            sub_sel = 1'b1;
         end
         OP_INC: begin
            b     = ONE;
            co_en = 1'b0;
         end
         OP_DEC: begin
            b       = ONE;
            sub_sel = 1'b1;
            co_en   = 1'b0;
         end
         default: co_en = 1'b0;
      endcase
   end

   always_comb begin
      if (sub_sel)
         ext = {1'b0, a} - {1'b0, b};
      else
         ext = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c_in};
      val = ext[WIDTH-1:0];
      co  = ext[WIDTH];
   end

   // Borrow from the subtractor must match an unsigned comparison.
   always_comb begin
      if (sub_sel) begin
         assert_borrow_R2: assert (co == (a < b));
      end
   end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
   import flag_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  alu_op_e                    op,
   input  logic [WIDTH-1:0]           d,
   input  logic [$clog2(WIDTH)-1:0]   cnt,
   input  logic                       cin,
   output logic [WIDTH-1:0]           val,
   output logic                       co,
   output logic                       co_en
);

   localparam int unsigned RING = WIDTH + 1;

   logic                   nz;
   logic [WIDTH:0]         lft, rgt;
   logic signed [WIDTH:0]  ars;
   logic [2*WIDTH-1:0]     rl, rr;
   logic [RING-1:0]        ring;
   logic [2*RING-1:0]      cl, cr;

   always_comb begin
      nz   = |cnt;
      lft  = {1'b0, d} << cnt;
      rgt  = {d, 1'b0} >> cnt;
      ars  = $signed({d, 1'b0}) >>> cnt;
      rl   = {d, d} << cnt;
      rr   = {d, d} >> cnt;
      ring = {cin, d};
      cl   = {ring, ring} << cnt;
      cr   = {ring, ring} >> cnt;
   end

   always_comb begin
      val   = d;
      co    = cin;
      co_en = nz;
      unique case (op)
         OP_SLL:  {co, val} = lft;
         OP_SRL:  {val, co} = rgt;
         OP_SRA:  {val, co} = ars;
         OP_ROTL: begin
            val = rl[2*WIDTH-1:WIDTH];
            co  = val[0];
         end
         OP_ROTR: begin
            val = rr[WIDTH-1:0];
            co  = val[WIDTH-1];
         end
         OP_RCL:  {co, val} = cl[2*RING-1:RING];
         OP_RCR:  {co, val} = cr[RING-1:0];
         default: co_en = 1'b0;
      endcase
   end

   // A zero count must pass D through untouched.
   always_comb begin
      if (!nz) begin
         assert_zero_count_R5: assert (val == d);
      end
   end

endmodule

// File: rtl/alu_logic_bit.sv
module alu_logic_bit
   import flag_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  alu_op_e          op,
   input  logic [WIDTH-1:0] d,
   input  logic [WIDTH-1:0] s,
   output logic [WIDTH-1:0] val,
   output logic             co,
   output logic             co_en
);

   localparam int unsigned IDX_W = $clog2(WIDTH);

   logic [IDX_W-1:0] idx;
   logic [WIDTH-1:0] mask;
   logic             sel_bit;

   always_comb begin
      idx     = s[IDX_W-1:0];
      mask    = {{(WIDTH-1){1'b0}}, 1'b1} << idx;
      sel_bit = d[idx];
   end

   always_comb begin
      val   = d;
      co    = 1'b0;
      co_en = 1'b1;
      unique case (op)
         OP_MOVE: begin
            val   = s;
            co_en = 1'b0;
         end
         OP_AND, OP_TEST: val = d & s;
         OP_OR:           val = d | s;
         OP_XOR:          val = d ^ s;
         OP_NOT:          val = ~d;
         OP_BTST:         co = sel_bit;
         OP_BCLR: begin
            co  = sel_bit;
            val = d & ~mask;
         end
         OP_BSET: begin
            co  = sel_bit;
            val = d | mask;
         end
         OP_CCLR: co = 1'b0;
         OP_CSET: co = 1'b1;
         default: co_en = 1'b0;
      endcase
   end

   // Clearing or setting a bit touches that bit only.
   always_comb begin
      if (op == OP_BCLR || op == OP_BSET) begin
         assert_single_bit_R9: assert ($countones(val ^ d) <= 1);
      end
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [4:0]       op_i,
   input  logic [WIDTH-1:0] d_i,
   input  logic [WIDTH-1:0] s_i,
   output logic             done_o,
   output logic             wr_o,
   output logic [WIDTH-1:0] res_o,
   output logic             cf_o,
   output logic             zf_o,
   output logic             sf_o
);

   localparam int unsigned IDX_W = $clog2(WIDTH);

   generate
      if (WIDTH < 4) begin : g_width_small
         $error("flag_alu: WIDTH must be at least 4");
      end
      if ((WIDTH & (WIDTH - 1)) != 0) begin : g_width_pow2
         $error("flag_alu: WIDTH must be a power of two");
      end
      if (OP_W != 5) begin : g_opw
         $error("flag_alu: operation code width mismatch");
      end
   endgenerate

   alu_op_e          op;
   alu_ctl_t         ctl;
   logic [WIDTH-1:0] a_val, s_val, l_val, val, new_d;
   logic             a_co, s_co, l_co, co;
   logic             a_en, s_en, l_en, co_en;

   logic             done_q, wr_q, cf_q, zf_q, sf_q;
   logic [WIDTH-1:0] res_q;

   assign op = alu_op_e'(op_i);

   always_comb begin
      ctl = '{unit: UNIT_LOGIC, wr: 1'b1, upd_zs: 1'b1};
      unique case (op)
         OP_ADD, OP_ADDC, OP_SUB, OP_NEG, OP_INC, OP_DEC:
            ctl.unit = UNIT_ARITH;
         OP_CMP: begin
            ctl.unit = UNIT_ARITH;
            ctl.wr   = 1'b0;
         end
         OP_SLL, OP_SRL, OP_SRA:
            ctl.unit = UNIT_SHIFT;
         OP_ROTL, OP_ROTR, OP_RCL, OP_RCR: begin
            ctl.unit   = UNIT_SHIFT;
            ctl.upd_zs = 1'b0;
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT: ;
         OP_TEST: ctl.wr = 1'b0;
         OP_MOVE, OP_BCLR, OP_BSET: ctl.upd_zs = 1'b0;
         OP_BTST, OP_CCLR, OP_CSET: begin
            ctl.wr     = 1'b0;
            ctl.upd_zs = 1'b0;
         end
         default: begin
            ctl.wr     = 1'b0;
            ctl.upd_zs = 1'b0;
         end
      endcase
   end

   alu_arith #(.WIDTH(WIDTH)) u_arith (
      .op    (op),
      .d     (d_i),
      .s     (s_i),
      .cin   (cf_q),
      .val   (a_val),
      .co    (a_co),
      .co_en (a_en)
   );

   alu_shift #(.WIDTH(WIDTH)) u_shift (
      .op    (op),
      .d     (d_i),
      .cnt   (s_i[IDX_W-1:0]),
      .cin   (cf_q),
      .val   (s_val),
      .co    (s_co),
      .co_en (s_en)
   );

   alu_logic_bit #(.WIDTH(WIDTH)) u_logic (
      .op    (op),
      .d     (d_i),
      .s     (s_i),
      .val   (l_val),
      .co    (l_co),
      .co_en (l_en)
   );

   always_comb begin
      unique case (ctl.unit)
         UNIT_ARITH: {val, co, co_en} = {a_val, a_co, a_en};
         UNIT_SHIFT: {val, co, co_en} = {s_val, s_co, s_en};
         default:    {val, co, co_en} = {l_val, l_co, l_en};
      endcase
      new_d = ctl.wr ? val : d_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         wr_q   <= 1'b0;
         res_q  <= '0;
         cf_q   <= 1'b0;
         zf_q   <= 1'b0;
         sf_q   <= 1'b0;
      end else begin
         done_q <= valid_i;
         wr_q   <= valid_i & ctl.wr;
         if (valid_i) begin
            res_q <= new_d;
            if (co_en) cf_q <= co;
            if (ctl.upd_zs) begin
               zf_q <= ~|val;
               sf_q <= val[WIDTH-1];
            end
         end
      end
   end

   assign done_o = done_q;
   assign wr_o   = wr_q;
   assign res_o  = res_q;
   assign cf_o   = cf_q;
   assign zf_o   = zf_q;
   assign sf_o   = sf_q;

   assert_cclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_CCLR) |=> !cf_o);

   assert_cset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == OP_CSET) |=> cf_o);

   assert_bit_keeps_zs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (op_i == OP_BTST || op_i == OP_BCLR || op_i == OP_BSET))
      |=> ($stable(zf_o) && $stable(sf_o)));

   assert_flag_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (op_i == OP_CMP || op_i == OP_TEST))
      |=> (!wr_o && res_o == $past(d_i)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> (!done_o && !wr_o && $stable(res_o) && $stable(cf_o)
                    && $stable(zf_o) && $stable(sf_o)));

   assert_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> done_o);

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
   import flag_alu_pkg::*;

   localparam int W = 8;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         valid_i = 1'b0;
   logic [4:0]   op_i = '0;
   logic [W-1:0] d_i = '0;
   logic [W-1:0] s_i = '0;
   logic         done_o, wr_o, cf_o, zf_o, sf_o;
   logic [W-1:0] res_o;

   int checks = 0;
   int errors = 0;
   int mcf = 0, mzf = 0, msf = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   flag_alu #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .d_i(d_i), .s_i(s_i), .done_o(done_o), .wr_o(wr_o), .res_o(res_o),
      .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o)
   );

   task automatic compare(input string tag, input string what,
                          input logic [W+4:0] got, input logic [W+4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual done/wr/res/cf/zf/sf=%b expected %b",
                  tag, what, got, exp);
      end
   endtask

   task automatic run_op(input alu_op_e op, input int d, input int s,
                         input string tag);
      int val, c, n, wr, cen, zs, nres;
      val = d; c = mcf; cen = 0; wr = 1; zs = 1;
      n = s % W;
      case (op)
         OP_ADD:  begin val = (d + s) & MASK; c = (d + s) >> W; cen = 1; end
         OP_ADDC: begin val = (d + s + mcf) & MASK; c = (d + s + mcf) >> W; cen = 1; end
         OP_SUB:  begin val = (d - s) & MASK; c = (d < s); cen = 1; end
         OP_CMP:  begin val = (d - s) & MASK; c = (d < s); cen = 1; wr = 0; end
         OP_NEG:  begin val = (0 - d) & MASK; c = (d != 0); cen = 1; end
         OP_INC:  val = (d + 1) & MASK;
         OP_DEC:  val = (d - 1) & MASK;
         OP_AND:  begin val = d & s; c = 0; cen = 1; end
         OP_OR:   begin val = d | s; c = 0; cen = 1; end
         OP_XOR:  begin val = d ^ s; c = 0; cen = 1; end
         OP_NOT:  begin val = ~d & MASK; c = 0; cen = 1; end
         OP_TEST: begin val = d & s; c = 0; cen = 1; wr = 0; end
         OP_MOVE: begin val = s; zs = 0; end
         OP_SLL: begin
            val = (d << n) & MASK;
            if (n != 0) begin c = (d >> (W - n)) & 1; cen = 1; end
         end
         OP_SRL: begin
            val = d >> n;
            if (n != 0) begin c = (d >> (n - 1)) & 1; cen = 1; end
         end
         OP_SRA: begin
            int sd;
            sd = (d >= (1 << (W - 1))) ? d - (1 << W) : d;
            val = (sd >>> n) & MASK;
            if (n != 0) begin c = (sd >>> (n - 1)) & 1; cen = 1; end
         end
         OP_ROTL, OP_ROTR, OP_RCL, OP_RCR: begin
            int cc;
            cc = mcf; zs = 0;
            for (int k = 0; k < n; k++) begin
               int nb;
               case (op)
                  OP_ROTL: begin val = ((val << 1) | (val >> (W - 1))) & MASK; cc = val & 1; end
                  OP_ROTR: begin val = (val >> 1) | ((val & 1) << (W - 1)); cc = val >> (W - 1); end
                  OP_RCL:  begin nb = val >> (W - 1); val = ((val << 1) | cc) & MASK; cc = nb; end
                  default: begin nb = val & 1; val = (val >> 1) | (cc << (W - 1)); cc = nb; end
               endcase
            end
            if (n != 0) begin c = cc; cen = 1; end
         end
         OP_BTST: begin c = (d >> n) & 1; cen = 1; wr = 0; zs = 0; end
         OP_BCLR: begin c = (d >> n) & 1; cen = 1; zs = 0; val = d & ~(1 << n) & MASK; end
         OP_BSET: begin c = (d >> n) & 1; cen = 1; zs = 0; val = d | (1 << n); end
         OP_CCLR: begin c = 0; cen = 1; wr = 0; zs = 0; end
         OP_CSET: begin c = 1; cen = 1; wr = 0; zs = 0; end
         default: begin wr = 0; zs = 0; end
      endcase
      nres = wr ? val : d;
      if (cen) mcf = c;
      if (zs) begin
         mzf = (val == 0);
         msf = (val >> (W - 1)) & 1;
      end
      @(negedge clk);
      valid_i = 1'b1; op_i = op; d_i = d[W-1:0]; s_i = s[W-1:0];
      @(negedge clk);
      valid_i = 1'b0;
      compare(tag, op.name(), {done_o, wr_o, res_o, cf_o, zf_o, sf_o},
              {1'b1, wr[0], nres[W-1:0], mcf[0], mzf[0], msf[0]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL R12 watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      compare("R1", "in reset", {done_o, wr_o, res_o, cf_o, zf_o, sf_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1", "after release", {done_o, wr_o, res_o, cf_o, zf_o, sf_o}, '0);

      // R10 carry forcing
      run_op(OP_CSET, 8'h5a, 0, "R10");
      run_op(OP_CCLR, 8'h5a, 0, "R10");

      // R2 / R3 / R11 arithmetic sweep
      for (int d = 0; d < 256; d += 17) begin
         for (int s = 0; s < 256; s += 15) begin
            run_op(OP_ADD, d, s, "R2");
            run_op(OP_ADDC, d, s, "R2");
            run_op(OP_SUB, d, s, "R2");
            run_op(OP_CMP, d, s, "R3");
            run_op(OP_ADDC, d, s, "R11");
            run_op(OP_TEST, d, s, "R3");
            run_op(OP_AND, d, s, "R4");
            run_op(OP_OR, d, s, "R4");
            run_op(OP_XOR, d, s, "R4");
            run_op(OP_MOVE, d, s, "R4");
         end
         run_op(OP_NEG, d, 0, "R2");
         run_op(OP_INC, d, 0, "R2");
         run_op(OP_DEC, d, 0, "R2");
         run_op(OP_NOT, d, 0, "R4");
      end
      run_op(OP_INC, 255, 0, "R11");
      run_op(OP_DEC, 0, 0, "R11");
      run_op(OP_NEG, 0, 0, "R2");
      run_op(OP_ADD, 255, 1, "R11");

      // R5 / R6 / R7 / R8 shifts and rotates, all counts, masked counts
      for (int d = 0; d < 256; d += 23) begin
         for (int s = 0; s < 32; s++) begin
            string t;
            t = (s >= W) ? "R8" : "R5";
            run_op(OP_SLL, d, s, t);
            run_op(OP_SRL, d, s, t);
            run_op(OP_SRA, d | 8'h80, s, t);
            run_op(OP_SRA, d & 8'h7f, s, t);
            t = (s >= W) ? "R8" : "R6";
            run_op(OP_ROTL, d, s, t);
            run_op(OP_ROTR, d, s, t);
            t = (s >= W) ? "R8" : "R7";
            run_op(OP_CSET, 0, 0, "R10");
            run_op(OP_RCL, d, s, t);
            run_op(OP_RCR, d, s, t);
            run_op(OP_CCLR, 0, 0, "R10");
            run_op(OP_RCL, d, s, t);
            run_op(OP_RCR, d, s, t);
         end
      end

      // R9 bit operations, every index, masked indices
      for (int d = 0; d < 256; d += 29) begin
         for (int s = 0; s < 24; s++) begin
            string t;
            t = (s >= W) ? "R8" : "R9";
            run_op(OP_SUB, d, 3, "R11");
            run_op(OP_BTST, d, s, t);
            run_op(OP_BCLR, d, s, t);
            run_op(OP_BSET, d, s, t);
         end
      end

      // R12 idle: outputs hold, strobes drop
      run_op(OP_ADD, 8'h12, 8'h34, "R12");
      held = res_o;
      repeat (4) @(negedge clk);
      compare("R12", "idle hold", {done_o, wr_o, res_o, cf_o, zf_o, sf_o},
              {1'b0, 1'b0, held, mcf[0], mzf[0], msf[0]});

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule